// File: doc/BRIEF.md
# Protection Switching Byte Monitor

This block follows the automatic protection switching code that arrives once per frame in the K1 byte and the upper five bits of the K2 byte. A 13-bit candidate is taken from each frame and goes into the status register only after it has been seen unchanged in a programmed number of back-to-back frames. When the accepted value differs from the one already held, a sticky change event is raised. This event can be masked. It drives a dedicated protection-switching interrupt and also feeds the general device interrupt.

A second counter measures instability. It counts successive frames that fail the acceptance test, and it raises a sticky babble event when the count reaches a programmed limit. A typical limit is 12. Loss of framing or a B1 parity error zeroes both counters. Software clears the events with write-one-to-clear pulses.

The persistence tracker is a three-state machine:
- `PS_EMPTY`: no run is in progress.
- `PS_RUN`: a run is in progress but is still below the threshold.
- `PS_HELD`: the run has reached the threshold.

Its transitions are named as follows:
- *clear*: any state goes to `PS_EMPTY` when framing is lost or a B1 error occurs.
- *start*: `PS_EMPTY` goes to `PS_RUN` or `PS_HELD` on the first frame.
- *extend*: the next state for an identical frame, chosen by comparing the run length with the threshold.
- *restart*: a differing frame sets the run back to 1. The next state is again chosen by the threshold.

Top module: `aps_monitor`

## Requirements
- R1: After reset, the status value is 0, both event bits are 0 and both interrupts are 0.
- R2: The candidate is {K1[7:0], K2[7:3]}, with K1 in bits 12:5. The status register takes the candidate on the strobe whose run of identical consecutive frames (this frame included) reaches the persistence threshold. The new value is visible in the cycle after that strobe's clock edge.
- R3: The change event bit is set in the same cycle that the status value changes, and at no other time. Once set, it stays set.
- R4: `aps_irq` equals change event AND NOT change mask. `dev_irq` equals `aps_irq` OR (babble event AND NOT babble mask).
- R5: Each strobed frame that fails the acceptance test adds one to the babble count, which saturates at 15. The babble event is set when an increment makes the count equal the limit. A frame that meets the test zeroes the count.
- R6: In any cycle where `oof` or `b1_err` is high, the run and babble counters go to 0 and a strobe in that cycle is discarded.
- R7: A high `delta_clr` or `babble_clr` clears its own event bit. A set in the same cycle takes priority.
- R8: A threshold or limit setting of 0 behaves as 1.
- R9: A candidate that differs from the previous frame's candidate restarts the run length at 1. The run length saturates at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse when the K bytes of a frame are valid |
| k1_byte | input | 8 | Received K1 byte |
| k2_byte | input | 8 | Received K2 byte (bits 7:3 used) |
| oof | input | 1 | Framer out-of-frame status |
| b1_err | input | 1 | B1 parity error flag |
| persist_cfg | input | 4 | Identical-frame threshold |
| babble_cfg | input | 4 | Babble frame limit |
| delta_mask | input | 1 | Masks the change event from the interrupts |
| babble_mask | input | 1 | Masks the babble event from the device interrupt |
| delta_clr | input | 1 | Write-one-to-clear for the change event |
| babble_clr | input | 1 | Write-one-to-clear for the babble event |
| aps_status | output | 13 | Accepted protection switching value |
| delta_evt | output | 1 | Sticky change event |
| babble_evt | output | 1 | Sticky babble event |
| aps_irq | output | 1 | Dedicated protection switching interrupt |
| dev_irq | output | 1 | General device interrupt contribution |

## Verification
The status value, the run and babble counts and both event bits are registered, so their response to a strobe, clear or framing input is due in the cycle after that input's clock edge. The two interrupts are combinational from the event bits and the masks, so they follow in that same cycle. The bench drives inputs at the falling edge and advances its behavioural model at each rising edge. It compares every output 1 ns after that edge, which is the first moment every registered result is due.

// File: rtl/aps_pkg.sv
package aps_pkg;

    localparam int APS_W   = 13;
    localparam int CFG_W   = 4;

    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_RUN   = 2'd1,
        PS_HELD  = 2'd2
    } run_state_e;

    function automatic logic [CFG_W-1:0] eff_thr(input logic [CFG_W-1:0] cfg);
        return (cfg == '0) ? CFG_W'(1) : cfg;
    endfunction

endpackage

// File: rtl/aps_persist.sv
module aps_persist
    import aps_pkg::*;
#(
    parameter int VAL_W = APS_W,
    parameter int CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             stb_i,
    input  logic [VAL_W-1:0] val_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             met_o
);

    localparam logic [CNT_W-1:0] RUN_MAX = '1;
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic [VAL_W-1:0] prev_q;
    logic [CNT_W-1:0] thr_eff;
    logic             same;
    logic             take;

    assign thr_eff = (thr_i == '0) ? RUN_ONE : thr_i;
    assign same    = (val_i == prev_q);
    assign take    = stb_i && !clr_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_EMPTY;
            run_q   <= '0;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            if (take) prev_q <= val_i;
        end
    end

    // next state and run length
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (clr_i) begin
            state_d = PS_EMPTY;
            run_d   = '0;
        end else if (stb_i) begin
            unique case (state_q)
                PS_EMPTY: run_d = RUN_ONE;
                PS_RUN,
                PS_HELD: begin
                    if (!same)                run_d = RUN_ONE;
                    else if (run_q != RUN_MAX) run_d = run_q + RUN_ONE;
                    else                       run_d = run_q;
                end
                default: run_d = RUN_ONE;
            endcase
            state_d = (run_d >= thr_eff) ? PS_HELD : PS_RUN;
        end
    end

    // outputs
    always_comb begin
        met_o = 1'b0;
        if (take) begin
            unique case (state_d)
                PS_HELD:  met_o = 1'b1;
                PS_RUN,
                PS_EMPTY: met_o = 1'b0;
                default:  met_o = 1'b0;
            endcase
        end
    end

    a_r6_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (run_q == '0 && state_q == PS_EMPTY));

    a_r9_restart_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        (take && state_q != PS_EMPTY && val_i != prev_q) |=> (run_q == RUN_ONE));

    a_r8_zero_thr_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (take && thr_i == '0) |-> met_o);

endmodule

// File: rtl/aps_babble.sv
module aps_babble
    import aps_pkg::*;
#(
    parameter int CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             stb_i,
    input  logic             met_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] BC_MAX = '1;
    localparam logic [CNT_W-1:0] BC_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_eff;
    logic             inc;

    assign lim_eff = (lim_i == '0) ? BC_ONE : lim_i;
    assign inc     = stb_i && !clr_i && !met_i && (cnt_q != BC_MAX);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                cnt_d = '0;
        else if (stb_i && met_i)  cnt_d = '0;
        else if (inc)             cnt_d = cnt_q + BC_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = inc && (cnt_d == lim_eff);

    a_r6_babble_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

    a_r5_met_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && met_i) |=> (cnt_q == '0));

    a_r5_hit_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (stb_i && !met_i));

endmodule

// File: rtl/aps_flags.sv
module aps_flags
    import aps_pkg::*;
#(
    parameter int VAL_W = APS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             met_i,
    input  logic [VAL_W-1:0] val_i,
    input  logic             hit_i,
    input  logic             delta_clr_i,
    input  logic             babble_clr_i,
    input  logic             delta_mask_i,
    input  logic             babble_mask_i,
    output logic [VAL_W-1:0] status_o,
    output logic             delta_o,
    output logic             babble_o,
    output logic             aps_irq_o,
    output logic             dev_irq_o
);

    logic [VAL_W-1:0] status_q;
    logic             delta_q, babble_q;
    logic             upd;

    assign upd = met_i && (val_i != status_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            delta_q  <= 1'b0;
            babble_q <= 1'b0;
        end else begin
            if (upd) status_q <= val_i;
            delta_q  <= upd   | (delta_q  & ~delta_clr_i);
            babble_q <= hit_i | (babble_q & ~babble_clr_i);
        end
    end

    assign status_o  = status_q;
    assign delta_o   = delta_q;
    assign babble_o  = babble_q;
    assign aps_irq_o = delta_q & ~delta_mask_i;
    assign dev_irq_o = aps_irq_o | (babble_q & ~babble_mask_i);

    a_r3_change_sets_delta: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_q) |-> delta_q);

    a_r2_change_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_q) |-> $past(met_i));

    a_r7_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(delta_q) && !$past(delta_clr_i)) |-> delta_q);

    a_r7_babble_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(babble_q) && !$past(babble_clr_i)) |-> babble_q);

endmodule

// File: rtl/aps_monitor.sv
module aps_monitor
    import aps_pkg::*;
#(
    parameter int VAL_W = APS_W,
    parameter int CNT_W = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic [7:0]       k1_byte,
    input  logic [7:0]       k2_byte,
    input  logic             oof,
    input  logic             b1_err,
    input  logic [CNT_W-1:0] persist_cfg,
    input  logic [CNT_W-1:0] babble_cfg,
    input  logic             delta_mask,
    input  logic             babble_mask,
    input  logic             delta_clr,
    input  logic             babble_clr,
    output logic [VAL_W-1:0] aps_status,
    output logic             delta_evt,
    output logic             babble_evt,
    output logic             aps_irq,
    output logic             dev_irq
);

    logic [VAL_W-1:0] cand;
    logic             frame_clr;
    logic             met;
    logic             hit;
    logic             unused_k2;

    assign cand      = VAL_W'({k1_byte, k2_byte[7:3]});
    assign frame_clr = oof | b1_err;
    assign unused_k2 = ^k2_byte[2:0];

    aps_persist #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_persist (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (frame_clr),
        .stb_i (frame_stb),
        .val_i (cand),
        .thr_i (persist_cfg),
        .met_o (met)
    );

    aps_babble #(.CNT_W(CNT_W)) u_babble (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (frame_clr),
        .stb_i (frame_stb),
        .met_i (met),
        .lim_i (babble_cfg),
        .hit_o (hit)
    );

    aps_flags #(.VAL_W(VAL_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .met_i         (met),
        .val_i         (cand),
        .hit_i         (hit),
        .delta_clr_i   (delta_clr),
        .babble_clr_i  (babble_clr),
        .delta_mask_i  (delta_mask),
        .babble_mask_i (babble_mask),
        .status_o      (aps_status),
        .delta_o       (delta_evt),
        .babble_o      (babble_evt),
        .aps_irq_o     (aps_irq),
        .dev_irq_o     (dev_irq)
    );

    a_r6_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clr && frame_stb) |=> $stable(aps_status));

endmodule

// File: tb/aps_monitor_tb.sv
`timescale 1ns/1ps
module aps_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [7:0]  k1_byte = '0, k2_byte = '0;
    logic        oof = 1'b0, b1_err = 1'b0;
    logic [3:0]  persist_cfg = 4'd3, babble_cfg = 4'd12;
    logic        delta_mask = 1'b0, babble_mask = 1'b0;
    logic        delta_clr = 1'b0, babble_clr = 1'b0;
    logic [12:0] aps_status;
    logic        delta_evt, babble_evt, aps_irq, dev_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int m_prev = 0, m_run = 0, m_status = 0, m_bc = 0;
    bit m_delta = 0, m_bab = 0;

    always #4 clk = ~clk;

    aps_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .k1_byte(k1_byte), .k2_byte(k2_byte), .oof(oof), .b1_err(b1_err),
        .persist_cfg(persist_cfg), .babble_cfg(babble_cfg),
        .delta_mask(delta_mask), .babble_mask(babble_mask),
        .delta_clr(delta_clr), .babble_clr(babble_clr),
        .aps_status(aps_status), .delta_evt(delta_evt), .babble_evt(babble_evt),
        .aps_irq(aps_irq), .dev_irq(dev_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int pt, bt, v;
        bit setd, setb;
        pt = (persist_cfg == 0) ? 1 : int'(persist_cfg);   // R8
        bt = (babble_cfg == 0) ? 1 : int'(babble_cfg);
        setd = 0; setb = 0;
        if (oof || b1_err) begin            // R6
            m_run = 0; m_bc = 0;
        end else if (frame_stb) begin
            v = (int'(k1_byte) << 5) | int'(k2_byte[7:3]);
            if (m_run == 0 || v != m_prev) m_run = 1;   // R9
            else if (m_run < 15) m_run++;
            m_prev = v;
            if (m_run >= pt) begin
                m_bc = 0;
                if (v != m_status) begin m_status = v; setd = 1; end
            end else if (m_bc < 15) begin
                m_bc++;
                if (m_bc == bt) setb = 1;
            end
        end
        m_delta = setd | (m_delta & !delta_clr);   // R7
        m_bab   = setb | (m_bab & !babble_clr);
    endtask

    task automatic compare();
        bit ei, ed;
        ei = m_delta & !delta_mask;
        ed = ei | (m_bab & !babble_mask);
        chk(aps_status == m_status[12:0], "R2 status", aps_status, m_status);
        chk(delta_evt == m_delta, "R3 delta_evt", delta_evt, m_delta);
        chk(babble_evt == m_bab, "R5 babble_evt", babble_evt, m_bab);
        chk(aps_irq == ei, "R4 aps_irq", aps_irq, ei);
        chk(dev_irq == ed, "R4 dev_irq", dev_irq, ed);
    endtask

    task automatic cyc(input bit stb, input logic [7:0] k1, input logic [7:0] k2,
                       input bit of, input bit b1, input bit dc, input bit bc);
        @(negedge clk);
        frame_stb = stb; k1_byte = k1; k2_byte = k2;
        oof = of; b1_err = b1; delta_clr = dc; babble_clr = bc;
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic frame(input logic [7:0] k1, input logic [7:0] k2);
        cyc(1, k1, k2, 0, 0, 0, 0);
        cyc(0, 8'h00, 8'h00, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(aps_status == 0 && !delta_evt && !babble_evt && !aps_irq && !dev_irq,
            "R1 reset", {aps_status, delta_evt, babble_evt}, 0);

        // R2/R3: three identical frames accepted; K2[2:0] ignored
        frame(8'hA5, 8'hB3); frame(8'hA5, 8'hB4); frame(8'hA5, 8'hB7);
        chk(aps_status == 13'h14B6, "R2 packing", aps_status, 13'h14B6);
        // R4: masking
        delta_mask = 1'b1; cyc(0, 0, 0, 0, 0, 0, 0);
        delta_mask = 1'b0; cyc(0, 0, 0, 0, 0, 0, 0);
        // R7: clear, and set-wins collision
        cyc(0, 0, 0, 0, 0, 1, 0);
        frame(8'h3C, 8'h08); frame(8'h3C, 8'h08);
        cyc(1, 8'h3C, 8'h08, 0, 0, 1, 0);
        chk(delta_evt == 1'b1, "R7 set wins", delta_evt, 1);
        cyc(0, 0, 0, 0, 0, 1, 0);

        // R3: same value re-accepted gives no change event
        repeat (4) frame(8'h3C, 8'h08);
        chk(delta_evt == 1'b0, "R3 no change", delta_evt, 0);

        // R5/R9: alternating values build babble to limit 12
        for (int i = 0; i < 14; i++) frame(i[0] ? 8'h11 : 8'h22, 8'h00);
        chk(babble_evt == 1'b1, "R5 babble limit", babble_evt, 1);
        babble_mask = 1'b1; cyc(0, 0, 0, 0, 0, 0, 1); babble_mask = 1'b0;

        // R6: OOF and B1 errors reset the run
        frame(8'h77, 8'h10); frame(8'h77, 8'h10);
        cyc(1, 8'h77, 8'h10, 1, 0, 0, 0);
        frame(8'h77, 8'h10);
        chk(aps_status != 13'h0EE2, "R6 oof restart", aps_status, 0);
        frame(8'h77, 8'h10);
        cyc(0, 0, 0, 0, 1, 0, 0);
        frame(8'h77, 8'h10); frame(8'h77, 8'h10); frame(8'h77, 8'h10);
        chk(aps_status == 13'h0EE2, "R6 accept after b1", aps_status, 13'h0EE2);

        // R8: zero thresholds behave as one
        persist_cfg = 4'd0; babble_cfg = 4'd0;
        cyc(0, 0, 0, 0, 0, 1, 1);
        frame(8'h5A, 8'hF8);
        chk(aps_status == 13'h0B5F, "R8 single frame", aps_status, 13'h0B5F);
        persist_cfg = 4'd2;
        frame(8'h01, 8'h00);
        chk(babble_evt == 1'b1, "R8 babble limit 0", babble_evt, 1);

        // R9 and saturation: long runs, random stress
        persist_cfg = 4'd15; babble_cfg = 4'd15;
        repeat (20) frame(8'h44, 8'h44);
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] kk;
            kk = ($urandom % 3 == 0) ? 8'h81 : (($urandom % 2) ? 8'h42 : 8'h18);
            if ($urandom % 64 == 0) persist_cfg = 4'($urandom);
            if ($urandom % 64 == 0) babble_cfg = 4'($urandom);
            delta_mask = ($urandom % 8 == 0);
            babble_mask = ($urandom % 8 == 0);
            cyc(($urandom % 10) < 7, kk, kk, ($urandom % 40) == 0, ($urandom % 40) == 0,
                ($urandom % 10) == 0, ($urandom % 10) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule